// File: doc/BRIEF.md
# Processor Idle Clock Gating Controller

This block produces the clock that drives a processor core and lets software put that core into an idle state by stopping its clock. A stop request is written through a small register port. It does not take effect at once. The block keeps the clock running until the core reports that the instruction it was working on has retired, and only then does it gate the clock off. An unmasked interrupt request restarts the clock with no software action, and so does a write to the enable register. A reset also leaves the clock running.

The processor clock also passes through its own rate divider. The divider setting is separate from anything applied to the bus clock. The divider lets through one full clock pulse every 1, 2, 4 or 8 bus-clock cycles. A new ratio only takes effect on a divided-clock boundary. The bus clock output is the input clock, unchanged. Other bus masters therefore keep running while the core sleeps.

Top module: `pclk_idle_ctrl`

## Requirements
- R1: After reset the processor clock runs at ratio 1, the status bit reads 1 and the configuration register reads 0.
- R2: A write with bit 0 set to the disable register (address 1) requests idle. A write to that address with bit 0 clear is ignored.
- R3: While a stop is pending, the processor clock keeps pulsing and status stays 1. After `insn_done` is seen, status reads 0 and no further processor clock pulses occur.
- R4: A request on `irq_req[i]` restarts a stopped clock only when mask bit i is 1. Masked requests leave it stopped.
- R5: An unmasked request takes priority over a disable write in the same cycle. It also cancels a pending stop, and a later `insn_done` does not stop the clock.
- R6: A write with bit 0 set to the enable register (address 0) restarts a stopped clock.
- R7: The status register (address 2) holds the clock-on state in bit 0. Read data appears with `rd_valid` one cycle after `rd_en`.
- R8: `mclk` toggles every cycle whether the processor clock runs or not.
- R9: The configuration register (address 3) holds the ratio code in bits [1:0], giving a ratio of 2^code, and the interrupt mask in bits [2+N_IRQ-1:2]. It reads back as written.
- R10: A ratio change waits for a divided-clock boundary. Every spacing between processor clock pulses therefore equals either the old ratio or the new one, and no pulse is shorter than a full input high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq_req | input | N_IRQ | Interrupt request lines |
| insn_done | input | 1 | Core reports that the current instruction has retired |
| mclk | output | 1 | Ungated bus clock |
| pclk | output | 1 | Gated and divided processor clock |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a divided period. Reaching it needs a slow ratio to be set first. The stimulus programs ratio code 3, lets the pulse train settle, and writes code 0 a few cycles after a pulse. It then records the time of every processor clock edge and checks that each spacing is 1 or 8 input cycles. A second hard case is a stop that is pending when a wake arrives. The bench holds `insn_done` low after the disable write, pulses an unmasked interrupt, and only then delivers the retire handshake, so the cancel path is exercised.

// File: rtl/pclk_idle_pkg.sv
package pclk_idle_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_IDLE  = 2'd2
    } run_state_e;

    localparam logic [1:0] ADDR_ENABLE  = 2'd0;
    localparam logic [1:0] ADDR_DISABLE = 2'd1;
    localparam logic [1:0] ADDR_STATUS  = 2'd2;
    localparam logic [1:0] ADDR_CONFIG  = 2'd3;
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
    import pclk_idle_pkg::*;
#(
    parameter int DW      = 8,
    parameter int N_IRQ   = 4,
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    input  logic               status,
    output logic [DW-1:0]      rd_data,
    output logic               rd_valid,
    output logic               set_req,
    output logic               clr_req,
    output logic [RATIO_W-1:0] ratio_req,
    output logic [N_IRQ-1:0]   irq_mask
);
    localparam int CFG_W = N_IRQ + RATIO_W;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [N_IRQ-1:0]   mask;
        logic [DW-1:0]      rdata;
        logic               rvalid;
    } regs_s;

    regs_s r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = rd_en;
        if (wr_en && wr_addr == ADDR_CONFIG) begin
            r_d.ratio = wr_data[RATIO_W-1:0];
            r_d.mask  = wr_data[CFG_W-1:RATIO_W];
        end
        if (rd_en) begin
            r_d.rdata = '0;
            case (rd_addr)
                ADDR_STATUS: r_d.rdata[0] = status;
                ADDR_CONFIG: r_d.rdata[CFG_W-1:0] = {r_q.mask, r_q.ratio};
                default:     r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign set_req   = wr_en && (wr_addr == ADDR_ENABLE) && wr_data[0];
    assign clr_req   = wr_en && (wr_addr == ADDR_DISABLE) && wr_data[0];
    assign ratio_req = r_q.ratio;
    assign irq_mask  = r_q.mask;
    assign rd_data   = r_q.rdata;
    assign rd_valid  = r_q.rvalid;

    // R7: data is valid exactly one cycle after the read strobe
    a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: rtl/pclk_idle_fsm.sv
module pclk_idle_fsm
    import pclk_idle_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_req,
    input  logic             clr_req,
    input  logic             insn_done,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_mask,
    output logic             run_d,
    output logic             status
);
    typedef struct packed {
        run_state_e st;
    } fsm_s;

    fsm_s f_d, f_q;
    logic wake;

    always_comb begin
        wake = |(irq_req & irq_mask);
        f_d  = f_q;
        case (f_q.st)
            ST_RUN:   if (clr_req && !wake) f_d.st = ST_DRAIN;
            ST_DRAIN: begin
                if (wake || set_req)  f_d.st = ST_RUN;
                else if (insn_done)   f_d.st = ST_IDLE;
            end
            ST_IDLE:  if (wake || set_req) f_d.st = ST_RUN;
            default:  f_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st <= ST_RUN;
        end else begin
            f_q <= f_d;
        end
    end

    assign run_d  = (f_d.st != ST_IDLE);
    assign status = (f_q.st != ST_IDLE);

    // R3: idle is only entered from a pending stop that saw the handshake
    a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_IDLE && $past(f_q.st) != ST_IDLE)
            |-> ($past(f_q.st) == ST_DRAIN && $past(insn_done)));
    // R2: a stop request leaves the running state unless a wake is present
    a_r2_request_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_RUN && clr_req && !(|(irq_req & irq_mask)))
            |=> f_q.st == ST_DRAIN);
    // R4: an unmasked request while stopped restarts the clock
    a_r4_wake_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_IDLE && (|(irq_req & irq_mask))) |=> f_q.st == ST_RUN);
    // R5: a wake wins over a disable written in the same cycle
    a_r5_wake_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_RUN && (|(irq_req & irq_mask))) |=> f_q.st == ST_RUN);
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_d,
    input  logic [RATIO_W-1:0] ratio_req,
    output logic               en_q
);
    localparam int CNT_W = (1 << RATIO_W) - 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [RATIO_W-1:0] ratio;
        logic               en;
    } div_s;

    div_s v_d, v_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        v_d = v_q;
        lim = (ONE << v_q.ratio) - ONE;
        if (!run_d)              v_d.cnt = '0;
        else if (v_q.cnt >= lim) v_d.cnt = '0;
        else                     v_d.cnt = v_q.cnt + ONE;
        if (v_d.cnt == '0) v_d.ratio = ratio_req;
        v_d.en = run_d && (v_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q.cnt   <= '0;
            v_q.ratio <= '0;
            v_q.en    <= 1'b1;
        end else begin
            v_q <= v_d;
        end
    end

    assign en_q = v_q.en;

    // R10: the active ratio changes only at a divided-clock boundary
    a_r10_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q.ratio != $past(v_q.ratio)) |-> (v_q.cnt == '0));
    // R10: back-to-back enables only when the preceding ratio was 1
    a_r10_no_short_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q.en && $past(v_q.en)) |-> ($past(v_q.ratio) == '0));
endmodule

// File: rtl/pclk_gate.sv
module pclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    output logic pclk
);
    typedef struct packed {
        logic g;
    } gate_s;

    gate_s g_d, g_q;

    always_comb begin
        g_d   = g_q;
        g_d.g = en_q;
    end

    // sampled while clk is low so the AND below never cuts a high phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.g <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign pclk = clk & g_q.g;
endmodule

// File: rtl/pclk_idle_ctrl.sv
module pclk_idle_ctrl
    import pclk_idle_pkg::*;
#(
    parameter int DW      = 8,
    parameter int N_IRQ   = 4,
    parameter int RATIO_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             insn_done,
    output logic             mclk,
    output logic             pclk
);
    logic               set_req, clr_req, run_d, status, en_q;
    logic [RATIO_W-1:0] ratio_req;
    logic [N_IRQ-1:0]   irq_mask;

    pclk_regs #(.DW(DW), .N_IRQ(N_IRQ), .RATIO_W(RATIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .status(status),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .set_req(set_req), .clr_req(clr_req),
        .ratio_req(ratio_req), .irq_mask(irq_mask)
    );

    pclk_idle_fsm #(.N_IRQ(N_IRQ)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .set_req(set_req), .clr_req(clr_req), .insn_done(insn_done),
        .irq_req(irq_req), .irq_mask(irq_mask),
        .run_d(run_d), .status(status)
    );

    pclk_divider #(.RATIO_W(RATIO_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .run_d(run_d), .ratio_req(ratio_req), .en_q(en_q)
    );

    pclk_gate u_gate (
        .clk(clk), .rst_n(rst_n), .en_q(en_q), .pclk(pclk)
    );

    assign mclk = clk;
endmodule

// File: tb/tb_pclk_idle_ctrl.sv
`timescale 1ns/1ps
module tb_pclk_idle_ctrl;
    localparam int DW = 8;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [NI-1:0] irq_req = '0;
    logic          insn_done = 1'b0;
    logic          mclk, pclk;

    int total = 0;
    int bad = 0;
    int pcnt = 0;
    int mcnt = 0;
    time pt[$];
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    pclk_idle_ctrl #(.DW(DW), .N_IRQ(NI), .RATIO_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .irq_req(irq_req),
        .insn_done(insn_done), .mclk(mclk), .pclk(pclk)
    );

    always @(posedge pclk) begin
        pcnt = pcnt + 1;
        pt.push_back($time);
    end
    always @(posedge mclk) mcnt = mcnt + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // scoreboard monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected read data", int'(rd_data), -1);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, int'(rd_data), int'(e));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [DW-1:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic window(input int n, input int ep, input string tag);
        int p0, m0;
        p0 = pcnt; m0 = mcnt;
        repeat (n) @(negedge clk);
        check((pcnt - p0) == ep, {tag, " pclk pulses"}, pcnt - p0, ep);
        check((mcnt - m0) == n, "R8 mclk keeps running", mcnt - m0, n);
    endtask

    task automatic pulse_done();
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nbad;
        int sp;
        int idx;
        idle_wait(3);
        rst_n = 1'b1;
        idle_wait(2);

        // R1 reset state
        rd(2'd2, 8'h01, "R1 status after reset");
        rd(2'd3, 8'h00, "R1 config after reset");
        window(32, 32, "R1 ratio 1 after reset");

        // R9 ratio codes and readback
        wr(2'd3, 8'h01);
        idle_wait(8);
        window(32, 16, "R9 ratio code 1");
        wr(2'd3, 8'h03);
        idle_wait(16);
        window(32, 4, "R9 ratio code 3");
        rd(2'd3, 8'h03, "R9 config readback ratio");

        // R10 ratio change mid period: spacings must be 8 or 1
        idle_wait(16);
        @(posedge pclk);
        @(negedge clk);
        idx = pt.size();
        idle_wait(3);
        wr(2'd3, 8'h00);
        idle_wait(20);
        nbad = 0;
        for (int i = idx; i < pt.size(); i++) begin
            sp = int'((pt[i] - pt[i-1]) / 20);
            if (sp != 1 && sp != 8) nbad++;
        end
        check(nbad == 0, "R10 pulse spacing old or new ratio only", nbad, 0);
        check(pt.size() - idx >= 15, "R10 new ratio in effect", pt.size() - idx, 15);

        // R2 write with bit0 clear is ignored
        wr(2'd1, 8'hFE);
        idle_wait(2);
        rd(2'd2, 8'h01, "R2 disable without bit0 ignored");
        window(8, 8, "R2 clock still running");

        // R3 pending stop waits for the handshake
        wr(2'd1, 8'h01);
        idle_wait(2);
        rd(2'd2, 8'h01, "R3 status while stop pending");
        window(16, 16, "R3 running while pending");
        pulse_done();
        idle_wait(2);
        rd(2'd2, 8'h00, "R3 status after handshake");
        window(32, 0, "R3 stopped after handshake");

        // R6 enable write restarts
        wr(2'd0, 8'h01);
        idle_wait(2);
        rd(2'd2, 8'h01, "R6 status after enable write");
        window(16, 16, "R6 clock restarted");

        // R4 mask: enable only line 0 (config bit 2), ratio code 0
        wr(2'd3, 8'h04);
        rd(2'd3, 8'h04, "R9 mask readback");
        wr(2'd1, 8'h01);
        pulse_done();
        idle_wait(2);
        irq_req = 4'b0010;
        idle_wait(4);
        rd(2'd2, 8'h00, "R4 masked line does not wake");
        window(16, 0, "R4 masked line keeps clock stopped");
        irq_req = 4'b0001;
        idle_wait(3);
        irq_req = 4'b0000;
        rd(2'd2, 8'h01, "R4 unmasked line wakes");
        window(16, 16, "R4 clock runs after wake");

        // R5 wake beats a same-cycle disable
        irq_req = 4'b0001;
        wr(2'd1, 8'h01);
        pulse_done();
        idle_wait(2);
        rd(2'd2, 8'h01, "R5 wake wins over disable");
        window(16, 16, "R5 clock kept running");
        irq_req = 4'b0000;

        // R5 wake cancels a pending stop
        wr(2'd1, 8'h01);
        idle_wait(2);
        irq_req = 4'b0001;
        @(negedge clk);
        irq_req = 4'b0000;
        idle_wait(2);
        pulse_done();
        idle_wait(2);
        rd(2'd2, 8'h01, "R5 pending stop cancelled");
        window(16, 16, "R5 no stop after late handshake");

        // R7 read of a write-only address returns zero
        rd(2'd0, 8'h00, "R7 enable address reads zero");

        idle_wait(4);
        check(exp_q.size() == 0, "R7 every read answered", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule